// File: doc/BRIEF.md
# Five-bit overlapping pattern detector

This block watches a serial bit stream, one bit per clock, and flags every place where the five most recent bits read 11011. It is a Mealy machine, so the flag follows the bit that is present in the same cycle as the bit that completes the pattern. Matches may share bits: the last two ones of a hit are kept as the first two ones of the next candidate. For example, the stream 11011011011 flags three times and not twice.

The state is held in three bits. Each bit is updated through its own set/clear (JK-style) excitation equations, which are turned into flip-flop updates in the RTL. A second next-state network, built from plain data-input equations, runs beside the JK network. Assertions compare the two networks, so the two derivations are kept equal on every legal state. The codes are picked sparsely: a zero input always leads to an even code, and a one input always leads to an odd code.

Top module: `pat5_detector`

## Requirements
- R1: A synchronous active-high `rst` puts the machine in the idle code 000 on the next edge, and `z_out` stays 0 while `rst` is high, whatever the input. History from before reset does not contribute to later matches.
- R2: `z_out` is 1 in exactly those cycles where the four bits accepted on earlier edges, followed by the current `x_in`, form 1,1,0,1,1. It is 0 in all other cycles. `z_out` is combinational from the state and `x_in`.
- R3: Overlap is allowed. The input 11011011011 gives the output 00001001001.
- R4: `z_out` is never 1 in two consecutive cycles.
- R5: The state codes are: idle 000, "1" seen 001, "11" seen 011, "110" seen 100, "1101" seen 101. With input 0 the moves are: 000→000, 001→000, 011→100, 100→000, 101→000. With input 1 the moves are: 000→001, 001→011, 011→011, 100→101, 101→011.
- R6: Each state bit follows the JK rule: hold, clear, set or toggle. The inputs are: bit 2 set = ~x·Y1 and clear = ~x + Y0; bit 1 set = x·Y0 and clear = ~x; bit 0 set = x and clear = ~x.
- R7: On every legal code, the data-input network (D2 = ~x·Y1 + x·Y2·~Y0, D1 = x·Y0, D0 = x) gives the same next state as the JK network.
- R8: From any unused code (010, 110, 111), the machine is back in a legal code within two clocks, for any input.
- R9: After a cycle with `z_out` = 1, the machine is in the "11" seen code 011.
- R10: Bits that break a partial match are handled correctly. Extra leading ones (1111011) still produce a hit on the last bit. A zero after 1101 restarts the search from idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| x_in | input | 1 | Serial data bit, one per clock |
| z_out | output | 1 | Match flag for the current bit |

## Verification
The embedded assertions check these on every cycle:
- the transition table against the state register;
- agreement between the JK and data-input networks on legal codes;
- the single-cycle width of the flag;
- the landing code after a hit;
- the bound on cycles spent in unused codes.

Only the bench scenarios can show the following:
- that the flag lines up with a five-bit window reference over a long biased random stream;
- the exact overlapped output of the reference stream;
- that reset mid-match drops the history.

The bench loads each unused code into the state register during reset and then drives a fixed preamble. This shows that the machine recovers into a state from which a normal match is detected.

// File: rtl/pat5_pkg.sv
package pat5_pkg;

    localparam int STATE_W = 3;

    typedef logic [STATE_W-1:0] code_t;

    localparam code_t ST_IDLE = 3'b000;
    localparam code_t ST_ONE  = 3'b001;
    localparam code_t ST_TWO  = 3'b011;
    localparam code_t ST_TRI  = 3'b100;
    localparam code_t ST_FOUR = 3'b101;

    typedef struct packed {
        logic [STATE_W-1:0] set_v;
        logic [STATE_W-1:0] clr_v;
    } exc_t;

    function automatic logic is_legal(input code_t c);
        return (c == ST_IDLE) || (c == ST_ONE) || (c == ST_TWO) ||
               (c == ST_TRI)  || (c == ST_FOUR);
    endfunction

    function automatic logic jk_step(input logic q, input logic j, input logic k);
        return (j & ~q) | (~k & q);
    endfunction

    // Transition table written by state name, used only as an independent check.
    function automatic code_t table_next(input code_t c, input logic x);
        code_t r;
        case (c)
            ST_IDLE: r = x ? ST_ONE : ST_IDLE;
            ST_ONE:  r = x ? ST_TWO : ST_IDLE;
            ST_TWO:  r = x ? ST_TWO : ST_TRI;
            ST_TRI:  r = x ? ST_FOUR : ST_IDLE;
            ST_FOUR: r = x ? ST_TWO : ST_IDLE;
            default: r = ST_IDLE;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/pat5_excite.sv
module pat5_excite
    import pat5_pkg::*;
(
    input  code_t q,
    input  logic  x,
    output exc_t  exc
);
    always_comb begin
        exc.set_v[2] = ~x & q[1];
        exc.clr_v[2] = ~x | q[0];
        exc.set_v[1] = x & q[0];
        exc.clr_v[1] = ~x;
        exc.set_v[0] = x;
        exc.clr_v[0] = ~x;
    end
endmodule

// File: rtl/pat5_jk_cell.sv
module pat5_jk_cell (
    input  logic q,
    input  logic j,
    input  logic k,
    output logic n
);
    always_comb n = pat5_pkg::jk_step(q, j, k);
endmodule

// File: rtl/pat5_d_shadow.sv
module pat5_d_shadow
    import pat5_pkg::*;
(
    input  code_t q,
    input  logic  x,
    output code_t n
);
    always_comb begin
        n[2] = (~x & q[1]) | (x & q[2] & ~q[0]);
        n[1] = x & q[0];
        n[0] = x;
    end
endmodule

// File: rtl/pat5_detector.sv
module pat5_detector
    import pat5_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic x_in,
    output logic z_out
);
    code_t state_q;
    code_t nxt_jk;
    code_t nxt_d;
    exc_t  exc;

    pat5_excite u_exc (
        .q   (state_q),
        .x   (x_in),
        .exc (exc)
    );

    for (genvar i = 0; i < STATE_W; i++) begin : g_bit
        pat5_jk_cell u_cell (
            .q (state_q[i]),
            .j (exc.set_v[i]),
            .k (exc.clr_v[i]),
            .n (nxt_jk[i])
        );
    end

    pat5_d_shadow u_dsh (
        .q (state_q),
        .x (x_in),
        .n (nxt_d)
    );

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= nxt_jk;
    end

    assign z_out = ~rst & x_in & state_q[2] & state_q[0];

    // ---------------- checks ----------------
    code_t      exp_q;
    logic       exp_vld_q;
    logic [1:0] ill_run_q;

    always_ff @(posedge clk) begin
        exp_q     <= table_next(state_q, x_in);
        exp_vld_q <= ~rst & is_legal(state_q);
        if (rst)                    ill_run_q <= '0;
        else if (is_legal(state_q)) ill_run_q <= '0;
        else if (ill_run_q != 2'd3) ill_run_q <= ill_run_q + 2'd1;
    end

    // R5
    table_move_chk: assert property (@(posedge clk) disable iff (rst)
        exp_vld_q |-> (state_q == exp_q));

    // R7
    jk_d_match_chk: assert property (@(posedge clk) disable iff (rst)
        is_legal(state_q) |-> (nxt_jk == nxt_d));

    // R4
    single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        z_out |=> !z_out);

    // R9
    hit_lands_chk: assert property (@(posedge clk) disable iff (rst)
        z_out |=> (state_q == ST_TWO));

    // R8
    recover_chk: assert property (@(posedge clk) disable iff (rst)
        ill_run_q != 2'd3);

endmodule

// File: tb/sim_pat5_detector.sv
module sim_pat5_detector;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic x_in = 1'b0;
    logic z_out;

    int checks = 0;
    int fails = 0;
    logic [3:0] hist = '0;

    always #2 clk = ~clk;

    pat5_detector u0 (
        .clk   (clk),
        .rst   (rst),
        .x_in  (x_in),
        .z_out (z_out)
    );

    function automatic logic ref_z(input logic [3:0] h, input logic b);
        return {h, b} == 5'b11011;
    endfunction

    task automatic chk(input logic got, input logic exp, input string req);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: z_out=%0b expected %0b at %0t", req, got, exp, $time);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        x_in = 1'b1;
        #1 chk(z_out, 1'b0, "R1 held low in reset");
        @(negedge clk);
        rst = 1'b0;
        x_in = 1'b0;
        hist = '0;
    endtask

    task automatic feed(input logic b, input string req);
        @(negedge clk);
        x_in = b;
        #1 chk(z_out, ref_z(hist, b), req);
        hist = {hist[2:0], b};
    endtask

    task automatic feed_exp(input logic b, input logic e, input string req);
        @(negedge clk);
        x_in = b;
        #1 chk(z_out, e, req);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [10:0] seq_in;
        logic [10:0] seq_out;
        int unsigned seed;
        seed = 32'd12345;
        void'($urandom(seed));

        repeat (2) @(posedge clk);
        do_reset();
        // R1: idle after reset, zero input gives no flag
        feed_exp(1'b0, 1'b0, "R1 idle after reset");
        hist = '0;

        // R3: overlapped reference stream
        seq_in  = 11'b11011011011;
        seq_out = 11'b00001001001;
        for (int i = 10; i >= 0; i--) begin
            feed_exp(seq_in[i], seq_out[i], "R3 overlap stream");
        end

        // R10: extra leading ones
        do_reset();
        foreach (seq_in[i]) ;
        begin
            logic [6:0] s;
            s = 7'b1111011;
            for (int i = 6; i >= 0; i--) feed(s[i], "R10 leading ones");
        end
        // R10: zero after 1101 restarts
        do_reset();
        begin
            logic [9:0] s;
            s = 10'b1101011011;
            for (int i = 9; i >= 0; i--) feed(s[i], "R10 break after 1101");
        end

        // R1: reset in the middle of a match drops history
        do_reset();
        feed(1'b1, "R2 prefix"); feed(1'b1, "R2 prefix");
        feed(1'b0, "R2 prefix"); feed(1'b1, "R2 prefix");
        do_reset();
        feed_exp(1'b1, 1'b0, "R1 no hit after reset");
        hist = 4'b0001;
        feed(1'b1, "R1 rebuild"); feed(1'b0, "R1 rebuild");
        feed(1'b1, "R1 rebuild"); feed_exp(1'b1, 1'b1, "R1 hit after rebuild");
        hist = 4'b1011;

        // R2 R6 R7: long biased random stream against window reference
        do_reset();
        for (int n = 0; n < 4000; n++) begin
            logic b;
            b = ($urandom % 10) < 7;
            feed(b, "R2 R6 random window");
        end

        // R8: load each unused code, two free bits, then a normal match
        for (int c = 0; c < 3; c++) begin
            logic [2:0] code;
            code = (c == 0) ? 3'b010 : (c == 1) ? 3'b110 : 3'b111;
            for (int v = 0; v < 4; v++) begin
                @(negedge clk);
                rst = 1'b1;
                x_in = 1'b0;
                @(negedge clk);
                force u0.state_q = code;
                #1 release u0.state_q;
                rst = 1'b0;
                x_in = v[0];
                @(negedge clk);
                x_in = v[1];
                feed_exp(1'b0, 1'b0, "R8 recovery preamble");
                feed_exp(1'b0, 1'b0, "R8 recovery preamble");
                feed_exp(1'b1, 1'b0, "R8 match after recovery");
                feed_exp(1'b1, 1'b0, "R8 match after recovery");
                feed_exp(1'b0, 1'b0, "R8 match after recovery");
                feed_exp(1'b1, 1'b0, "R8 match after recovery");
                feed_exp(1'b1, 1'b1, "R8 match after recovery");
            end
        end

        do_reset();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule